// File: doc/BRIEF.md
# Host Command Latch and Compare

This block takes command bytes from a host computer and turns them into held control values for device programming logic. The host drives an 8-bit data bus whose lines are active low, and it uses three separate active-low strobes:

- The mode strobe captures a combined byte. Its upper half holds four mode bits and its lower half holds the top four bits of a 12-bit device address.
- The low-address strobe captures the lower eight address bits.
- The data strobe captures the byte to be programmed and starts a program operation.

Each strobe is brought into the clock domain through a synchroniser, and its falling edge is detected there. Each strobe assertion therefore loads its register exactly once, however long the host holds the strobe low.

The latched mode bits are exported as levels: a spare control bit, a read-go request, a socket select and a nibble select. Socket and nibble select are also packed into a 4-bit input port for the sequencing controller. A comparator checks the latched write byte against the byte read back from the target device. It gives the controller a single match flag, which the controller uses to verify the programmed location.

Top module: `host_cmd_latch`

## Requirements
- R1: After reset every held value is 0: `dev_addr`, `wr_byte`, all mode outputs, `ctl_in`, `prog_start` and `match`.
- R2: Stored values are the bitwise inverse of the bus levels on `host_data_n`, so a bus level of 0 stores a 1.
- R3: A falling edge on `wr_mode_n` stores the inverted byte. Its bits 7..4 go to the mode bits and its bits 3..0 go to `dev_addr[11:8]`. `dev_addr[7:0]` is left unchanged.
- R4: A falling edge on `wr_low_n` stores the inverted byte into `dev_addr[7:0]`, where bit 0 is the address LSB. `dev_addr[11:8]` is left unchanged.
- R5: A falling edge on `wr_data_n` stores the inverted byte in `wr_byte`. In the same cycle `prog_start` is high for exactly one clock cycle.
- R6: Each register loads once per strobe assertion. Bus changes while a strobe is still held low have no effect, and a held data strobe produces only one `prog_start` pulse.
- R7: `ctl_in` bit 0 carries the socket select (mode bit 5). Bit 1 carries the nibble select (mode bit 4). Bits 3..2 are always 0.
- R8: While `wide_word` is 1, meaning the device is organised as 8-bit words, `ctl_in` bit 1 reads 0. `nib_sel` still reports the stored bit.
- R9: `match` is 1 exactly when `wr_byte` equalled `rd_back` on the previous clock edge, and 0 otherwise.
- R10: `spare_ctl` reports mode bit 7. `read_go` reports mode bit 6, and a 1 requests a read-data operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_data_n | input | 8 | Host data bus, active low |
| wr_mode_n | input | 1 | Mode/high-address strobe, active low |
| wr_low_n | input | 1 | Low-address strobe, active low |
| wr_data_n | input | 1 | Write-data strobe, active low; starts a program operation |
| rd_back | input | 8 | Byte read back from the target device |
| wide_word | input | 1 | 1 when the device uses 8-bit words |
| dev_addr | output | 12 | Latched device address |
| wr_byte | output | 8 | Latched write data |
| spare_ctl | output | 1 | Spare control bit, latched only |
| read_go | output | 1 | Read-data request bit |
| sock_sel | output | 1 | Socket select bit |
| nib_sel | output | 1 | Nibble select bit |
| ctl_in | output | 4 | Controller input port {0,0,nibble,socket} |
| prog_start | output | 1 | One-cycle program start pulse |
| match | output | 1 | Write data equals read-back data |

## Verification
The bench holds strobes low for several cycles and changes the bus partway through. This exposes a level-sensitive latch, which would pick up the later byte, and a missing edge detector, which would fire a train of `prog_start` pulses that the scoreboard flags as unexpected.

Two alternating address writes show whether one strobe disturbs the other half of the address. Bus levels are chosen so that a missing inversion or a swapped nibble gives a visibly different value.

With `wide_word` set, the bench confirms that the nibble select is masked only on the controller port. The comparator is driven with equal bytes and with bytes differing by one bit, and the all-zero and all-one write bytes are also exercised.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;
  // Mode nibble as carried in the upper half of the mode/high-address byte
  typedef struct packed {
    logic spare;   // bit 7
    logic rd_go;   // bit 6
    logic sock;    // bit 5
    logic nib;     // bit 4
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Strobe indices
  localparam int STB_MODE = 0;
  localparam int STB_LOW  = 1;
  localparam int STB_DATA = 2;
  localparam int STB_N    = 3;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fire
);
  // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synchronised level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], strobe_n};
  end

  assign fire = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/field_reg.sv
module field_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/byte_compare.sv
module byte_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  always_ff @(posedge clk) begin
    if (rst) eq <= 1'b0;
    else     eq <= (a == b);
  end
endmodule

// File: rtl/host_cmd_latch.sv
module host_cmd_latch
  import host_cmd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_data_n,
  input  logic              wr_mode_n,
  input  logic              wr_low_n,
  input  logic              wr_data_n,
  input  logic [DATA_W-1:0] rd_back,
  input  logic              wide_word,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] wr_byte,
  output logic              spare_ctl,
  output logic              read_go,
  output logic              sock_sel,
  output logic              nib_sel,
  output logic [3:0]        ctl_in,
  output logic              prog_start,
  output logic              match
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] bus_val;
  logic [STB_N-1:0]  strobes_n;
  logic [STB_N-1:0]  fire;
  logic [HI_W-1:0]   addr_hi;
  logic [DATA_W-1:0] addr_lo;
  mode_t             mode_q;

  assign bus_val   = ~host_data_n;
  assign strobes_n = {wr_data_n, wr_low_n, wr_mode_n};

  for (genvar g = 0; g < STB_N; g++) begin : g_stb
    strobe_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk     (clk),
      .rst     (rst),
      .strobe_n(strobes_n[g]),
      .fire    (fire[g])
    );
  end

  field_reg #(.W(MODE_W)) i_mode (
    .clk (clk), .rst(rst), .load(fire[STB_MODE]),
    .d   (bus_val[DATA_W-1 -: MODE_W]), .q(mode_q)
  );

  field_reg #(.W(HI_W)) i_addr_hi (
    .clk (clk), .rst(rst), .load(fire[STB_MODE]),
    .d   (bus_val[HI_W-1:0]), .q(addr_hi)
  );

  field_reg #(.W(DATA_W)) i_addr_lo (
    .clk (clk), .rst(rst), .load(fire[STB_LOW]),
    .d   (bus_val), .q(addr_lo)
  );

  field_reg #(.W(DATA_W)) i_wdata (
    .clk (clk), .rst(rst), .load(fire[STB_DATA]),
    .d   (bus_val), .q(wr_byte)
  );

  byte_compare #(.W(DATA_W)) i_cmp (
    .clk(clk), .rst(rst), .a(wr_byte), .b(rd_back), .eq(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_start <= 1'b0;
      ctl_in     <= '0;
    end else begin
      prog_start <= fire[STB_DATA];
      ctl_in     <= {2'b00, mode_q.nib & ~wide_word, mode_q.sock};
    end
  end

  assign dev_addr  = {addr_hi, addr_lo};
  assign spare_ctl = mode_q.spare;
  assign read_go   = mode_q.rd_go;
  assign sock_sel  = mode_q.sock;
  assign nib_sel   = mode_q.nib;
endmodule

// File: rtl/host_cmd_latch_chk.sv
module host_cmd_latch_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_word,
  input logic [DATA_W-1:0] rd_back,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [DATA_W-1:0] wr_byte,
  input logic              nib_sel,
  input logic              sock_sel,
  input logic [3:0]        ctl_in,
  input logic              prog_start,
  input logic              match
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (dev_addr == '0 && wr_byte == '0 && !prog_start && !match));

  // R5
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  // R5
  wdata_only_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_start |-> $stable(wr_byte));

  // R7
  port_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_in[3:2] == 2'b00);

  // R7
  port_sock_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ctl_in[0] == $past(sock_sel));

  // R8
  nib_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wide_word) |-> !ctl_in[1]);

  // R9
  match_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> match == ($past(wr_byte) == $past(rd_back)));
endmodule

bind host_cmd_latch host_cmd_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wide_word (wide_word),
  .rd_back   (rd_back),
  .dev_addr  (dev_addr),
  .wr_byte   (wr_byte),
  .nib_sel   (nib_sel),
  .sock_sel  (sock_sel),
  .ctl_in    (ctl_in),
  .prog_start(prog_start),
  .match     (match)
);

// File: tb/test_host_cmd_latch.sv
`timescale 1ns/1ps
module test_host_cmd_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_data_n = 8'hFF;
  logic        wr_mode_n = 1'b1, wr_low_n = 1'b1, wr_data_n = 1'b1;
  logic [7:0]  rd_back = 8'hFF;
  logic        wide_word = 1'b0;
  logic [11:0] dev_addr;
  logic [7:0]  wr_byte;
  logic        spare_ctl, read_go, sock_sel, nib_sel, prog_start, match;
  logic [3:0]  ctl_in;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_cmd_latch i_host_cmd_latch (
    .clk(clk), .rst(rst), .host_data_n(host_data_n),
    .wr_mode_n(wr_mode_n), .wr_low_n(wr_low_n), .wr_data_n(wr_data_n),
    .rd_back(rd_back), .wide_word(wide_word),
    .dev_addr(dev_addr), .wr_byte(wr_byte), .spare_ctl(spare_ctl),
    .read_go(read_go), .sock_sel(sock_sel), .nib_sel(nib_sel),
    .ctl_in(ctl_in), .prog_start(prog_start), .match(match)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe with optional change of bus value while the strobe is still low
  task automatic pulse(input int which, input logic [7:0] val,
                       input bit glitch, input logic [7:0] val2);
    @(negedge clk);
    host_data_n = ~val;
    @(negedge clk);
    case (which)
      0: wr_mode_n = 1'b0;
      1: wr_low_n  = 1'b0;
      default: wr_data_n = 1'b0;
    endcase
    idle(4);
    if (glitch) begin
      host_data_n = ~val2;
      idle(5);
    end
    wr_mode_n = 1'b1; wr_low_n = 1'b1; wr_data_n = 1'b1;
    idle(4);
  endtask

  task automatic data_write(input logic [7:0] val, input bit glitch, input logic [7:0] val2);
    exp_q.push_back(val);
    pulse(2, val, glitch, val2);
  endtask

  // Scoreboard monitor: every prog_start pulse must match a queued write
  always @(negedge clk) begin
    if (!rst && prog_start) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected prog_start", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        // R5
        chk(wr_byte == e, "R5 wr_byte at prog_start", wr_byte, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1
    chk(dev_addr == 0 && wr_byte == 0 && ctl_in == 0 && !prog_start, "R1 reset addr/data",
        {dev_addr, wr_byte}, 0);
    chk({spare_ctl, read_go, sock_sel, nib_sel} == 0, "R1 reset mode",
        {spare_ctl, read_go, sock_sel, nib_sel}, 0);
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R3 R2 R10: bus carries ~A5
    pulse(0, 8'hA5, 1'b0, 8'h00);
    chk(dev_addr == 12'h500, "R3 high addr", dev_addr, 12'h500);
    chk({spare_ctl, read_go, sock_sel, nib_sel} == 4'hA, "R10 R3 mode bits",
        {spare_ctl, read_go, sock_sel, nib_sel}, 4'hA);
    chk(ctl_in == 4'b0001, "R7 port socket", ctl_in, 4'b0001);

    // R4 R2
    pulse(1, 8'h3C, 1'b0, 8'h00);
    chk(dev_addr == 12'h53C, "R4 low addr", dev_addr, 12'h53C);

    pulse(0, 8'h5E, 1'b0, 8'h00);
    chk(dev_addr == 12'hE3C, "R3 low half kept", dev_addr, 12'hE3C);
    chk({spare_ctl, read_go} == 2'b01, "R10 read_go", {spare_ctl, read_go}, 2'b01);
    chk(ctl_in == 4'b0010, "R7 port nibble", ctl_in, 4'b0010);

    // R8
    wide_word = 1'b1;
    idle(2);
    chk(ctl_in == 4'b0000, "R8 nibble masked", ctl_in, 4'b0000);
    chk(nib_sel == 1'b1, "R8 nib_sel kept", nib_sel, 1);
    wide_word = 1'b0;
    idle(2);
    chk(ctl_in == 4'b0010, "R8 unmasked", ctl_in, 4'b0010);

    // R6 on address strobe: second byte must be ignored
    pulse(1, 8'h81, 1'b1, 8'h7E);
    chk(dev_addr == 12'hE81, "R6 held low strobe", dev_addr, 12'hE81);

    // R5 R9
    data_write(8'h96, 1'b0, 8'h00);
    chk(wr_byte == 8'h96, "R5 wr_byte", wr_byte, 8'h96);
    rd_back = 8'h96; idle(2);
    chk(match == 1'b1, "R9 equal", match, 1);
    rd_back = 8'h97; idle(2);
    chk(match == 1'b0, "R9 one-bit diff", match, 0);

    // R6 on data strobe: one pulse, first byte kept
    data_write(8'h11, 1'b1, 8'h22);
    chk(wr_byte == 8'h11, "R6 data held", wr_byte, 8'h11);

    // boundaries
    data_write(8'h00, 1'b0, 8'h00);
    rd_back = 8'h00; idle(2);
    chk(match == 1'b1, "R9 zero byte", match, 1);
    data_write(8'hFF, 1'b0, 8'h00);
    idle(1);
    chk(match == 1'b0, "R9 after new write", match, 0);
    chk(dev_addr == 12'hE81, "R4 addr untouched by data", dev_addr, 12'hE81);
    chk(exp_q.size() == 0, "R5 all pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule